// File: doc/BRIEF.md
# Selectable-Clock Timer Channel

This block is one channel of a general-purpose up-counter that lives entirely in a single peripheral clock domain. It does not count on its own clock. Instead, it takes a count clock from one of eight sources. Five are internal prescaler ticks, which arrive as one-cycle enable pulses. Three are external clock inputs, which the block samples with a two-stage synchronizer and converts into edge pulses. An external source can be inverted so that its falling edges count. Any source can be gated by one of the three synchronized external levels, so that counting only happens while that level is high.

A trigger, from software or hardware, arms a pending reset. The counter does not clear at once: it loads zero on the next valid count edge, and that edge is not also counted as an increment. When the counter wraps from its all-ones value to zero, a sticky overflow flag is set. A status-read strobe clears the flag. The count value is driven live on an output port. A channel enable input freezes counting while it is low.

Top module: `tcc_channel`

## Requirements
- R1: After reset, `count_val` is 0 and `ovf_flag` is 0, and no trigger is pending. Reset asserts asynchronously and is released through a two-flop synchronizer.
- R2: With `clk_sel` set to a code from 0 to 4, each cycle where `int_tick[clk_sel]` is high adds one to `count_val`, visible after the next rising `clk` edge. Pulses on any other `int_tick` bit have no effect.
- R3: With `clk_sel` set to a code from 5 to 7, rising edges of `ext_clk[clk_sel-5]` are counted. The increment for a change applied before `clk` edge k shows on `count_val` after edge k+2.
- R4: With `clk_inv` = 1, an external source is counted on its falling edges instead of its rising edges. `clk_inv` has no effect on the internal tick sources.
- R5: A `burst_sel` of 0 means no gate. A `burst_sel` code b from 1 to 3 allows counting only while the synchronized `ext_clk[b-1]` is high. An edge seen while that level is low is dropped.
- R6: A count edge that finds `count_val` equal to 16'hFFFF, with no trigger pending, makes the count 0 and sets `ovf_flag`. The flag then stays set while later counting goes on.
- R7: `sts_rd` high clears `ovf_flag` on the next edge. If an overflow occurs in the same cycle as the read, the flag stays set.
- R8: A `trig` pulse leaves `count_val` unchanged until the next valid count edge, which loads 0 instead of incrementing. A trigger that coincides with a count edge takes effect at that edge. The edge after that counts up from 0.
- R9: While `chan_en` is low, `count_val` does not change, whatever the source activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Counting enable |
| clk_sel | input | 3 | Count source: 0-4 internal tick, 5-7 external input |
| clk_inv | input | 1 | Count falling edges of an external source |
| burst_sel | input | 2 | Gate: 0 none, 1-3 external input level 0-2 |
| int_tick | input | 5 | Internal prescaler tick pulses |
| ext_clk | input | 3 | Asynchronous external clock inputs |
| trig | input | 1 | Trigger: reset the count on the next valid edge |
| sts_rd | input | 1 | Status-read strobe, clears the overflow flag |
| count_val | output | 16 | Live counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land in the same cycle, and each pair is provoked on purpose. The first pair is a trigger and a count edge. The bench raises `trig` and a tick together, then checks that the count becomes 0 and does not become the incremented value. The second pair is an overflow and a status read. The bench steps the counter to 16'hFFFF and then applies the wrapping tick with `sts_rd` high. It judges the result by `ovf_flag` still being set afterwards, and by a later lone read clearing it.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int TCC_N_INT   = 5;
  localparam int TCC_N_EXT   = 3;
  localparam int TCC_SEL_W   = $clog2(TCC_N_INT + TCC_N_EXT);
  localparam int TCC_BURST_W = $clog2(TCC_N_EXT + 1);

  typedef logic [TCC_N_EXT-1:0] ext_vec_t;
  typedef logic [TCC_N_INT-1:0] tick_vec_t;
endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_rest
        assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tcc_edge_sel.sv
module tcc_edge_sel
  import tcc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chan_en,
  input  logic [TCC_SEL_W-1:0]   clk_sel,
  input  logic                   clk_inv,
  input  logic [TCC_BURST_W-1:0] burst_sel,
  input  tick_vec_t              int_tick,
  input  ext_vec_t               xc_sync,
  output logic                   cnt_pulse
);
  ext_vec_t xc_prev_q, xc_prev_d;
  ext_vec_t xc_rise, xc_fall;
  logic     src_edge, gate_ok;

  assign xc_prev_d = xc_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xc_prev_q <= '0;
    else        xc_prev_q <= xc_prev_d;
  end

  always_comb begin
    xc_rise  = xc_sync & ~xc_prev_q;
    xc_fall  = ~xc_sync & xc_prev_q;
    src_edge = 1'b0;
    for (int i = 0; i < TCC_N_INT; i++)
      if (clk_sel == TCC_SEL_W'(i)) src_edge = int_tick[i];
    for (int j = 0; j < TCC_N_EXT; j++)
      if (clk_sel == TCC_SEL_W'(TCC_N_INT + j))
        src_edge = clk_inv ? xc_fall[j] : xc_rise[j];
    gate_ok = 1'b1;
    for (int j = 0; j < TCC_N_EXT; j++)
      if (burst_sel == TCC_BURST_W'(j + 1)) gate_ok = xc_sync[j];
    cnt_pulse = chan_en & src_edge & gate_ok;
  end
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_pulse,
  input  logic             trig,
  input  logic             sts_rd,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             ovf_q, ovf_d;
  logic             trig_eff, wrap;

  always_comb begin
    trig_eff = pend_q | trig;
    cnt_d    = cnt_q;
    pend_d   = trig_eff;
    ovf_d    = ovf_q;
    wrap     = 1'b0;
    if (sts_rd) ovf_d = 1'b0;
    if (cnt_pulse) begin
      pend_d = 1'b0;
      if (trig_eff) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = &cnt_q;
      end
    end
    if (wrap) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;

  assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(cnt_q));
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && !trig_eff) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_trigger_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && trig_eff) |=> (cnt_q == '0));
  assert_trigger_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_pulse) |=> pend_q);
  assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && !trig_eff && (&cnt_q)) |=> ovf_q);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !sts_rd) |=> ovf_q);
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chan_en,
  input  logic [TCC_SEL_W-1:0]   clk_sel,
  input  logic                   clk_inv,
  input  logic [TCC_BURST_W-1:0] burst_sel,
  input  logic [TCC_N_INT-1:0]   int_tick,
  input  logic [TCC_N_EXT-1:0]   ext_clk,
  input  logic                   trig,
  input  logic                   sts_rd,
  output logic [CNT_W-1:0]       count_val,
  output logic                   ovf_flag
);
  logic     rst_sync_n;
  ext_vec_t xc_sync;
  logic     cnt_pulse;

  tcc_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  tcc_sync #(.W(TCC_N_EXT), .STAGES(SYNC_STAGES)) u_xc_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ext_clk),
    .q     (xc_sync)
  );

  tcc_edge_sel u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .chan_en   (chan_en),
    .clk_sel   (clk_sel),
    .clk_inv   (clk_inv),
    .burst_sel (burst_sel),
    .int_tick  (int_tick),
    .xc_sync   (xc_sync),
    .cnt_pulse (cnt_pulse)
  );

  tcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt_pulse (cnt_pulse),
    .trig      (trig),
    .sts_rd    (sts_rd),
    .count     (count_val),
    .ovf       (ovf_flag)
  );

  assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chan_en |=> $stable(count_val));
  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (burst_sel == TCC_BURST_W'(1) && !xc_sync[0]) |=> $stable(count_val));
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (count_val == '0 && !ovf_flag));
endmodule

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
  logic        clk;
  logic        rst_n;
  logic        chan_en;
  logic [2:0]  clk_sel;
  logic        clk_inv;
  logic [1:0]  burst_sel;
  logic [4:0]  int_tick;
  logic [2:0]  ext_clk;
  logic        trig;
  logic        sts_rd;
  logic [15:0] count_val;
  logic        ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  tcc_channel uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .clk_sel(clk_sel),
    .clk_inv(clk_inv), .burst_sel(burst_sel), .int_tick(int_tick),
    .ext_clk(ext_clk), .trig(trig), .sts_rd(sts_rd),
    .count_val(count_val), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int idx);
    int_tick[idx] = 1'b1;
    @(negedge clk);
    int_tick = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_level(input int idx, input logic lvl, input int hold);
    ext_clk[idx] = lvl;
    wait_cyc(hold);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    rst_n = 1'b0; chan_en = 1'b1; clk_sel = '0; clk_inv = 1'b0; burst_sel = '0;
    int_tick = '0; ext_clk = '0; trig = 1'b0; sts_rd = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 count", {16'b0, count_val}, 32'h0);
    check("R1 ovf", {31'b0, ovf_flag}, 32'h0);

    // R1: a pending trigger must not survive reset; a tick then counts to 1
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1; wait_cyc(4);
    tick(0);
    check("R1 no pending trigger", {16'b0, count_val}, 32'h1);

    // R2 R4 R5: internal sources across gate codes and levels
    for (int s = 0; s < 5; s++) begin
      for (int b = 0; b < 4; b++) begin
        for (int lvl = 0; lvl < 2; lvl++) begin
          if (b == 0 && lvl == 1) continue;
          clk_sel = 3'(s); burst_sel = 2'(b); clk_inv = s[0];
          ext_clk = (lvl == 1) ? 3'b111 : 3'b000;
          wait_cyc(4);
          base = count_val;
          for (int k = 0; k < 3 + s; k++) tick(s);
          int_tick = ~(5'b1 << s); @(negedge clk); int_tick = '0;
          check((b == 0) ? "R2 internal count" : "R5 burst gate",
                {16'b0, 16'(count_val - base)},
                (b == 0 || lvl == 1) ? 32'(3 + s) : 32'h0);
        end
      end
    end
    ext_clk = '0; burst_sel = '0; clk_inv = 1'b0;
    wait_cyc(4);

    // R3: latency of an external rising edge
    clk_sel = 3'd5;
    wait_cyc(2);
    base = count_val;
    ext_clk[0] = 1'b1;
    wait_cyc(2);
    check("R3 not yet counted", {16'b0, count_val}, {16'b0, base});
    wait_cyc(1);
    check("R3 counted after third edge", {16'b0, 16'(count_val - base)}, 32'h1);
    wait_cyc(3);
    ext_clk[0] = 1'b0;
    wait_cyc(5);

    // R3 R4: external sources with and without inversion
    for (int s = 5; s < 8; s++) begin
      for (int inv = 0; inv < 2; inv++) begin
        clk_sel = 3'(s); clk_inv = inv[0];
        wait_cyc(4);
        base = count_val;
        for (int k = 0; k < 3; k++) begin
          ext_level(s - 5, 1'b1, 4);
          ext_level(s - 5, 1'b0, 4);
        end
        ext_level(s - 5, 1'b1, 5);
        check(inv ? "R4 falling edges" : "R3 rising edges",
              {16'b0, 16'(count_val - base)}, inv ? 32'd3 : 32'd4);
        ext_level(s - 5, 1'b0, 5);
      end
    end
    clk_inv = 1'b0; clk_sel = 3'd0;

    // R8: deferred trigger
    for (int k = 0; k < 5; k++) tick(0);
    base = count_val;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    check("R8 trigger deferred", {16'b0, count_val}, {16'b0, base});
    wait_cyc(3);
    check("R8 still deferred", {16'b0, count_val}, {16'b0, base});
    tick(0);
    check("R8 zero on next edge", {16'b0, count_val}, 32'h0);
    tick(0);
    check("R8 counts from zero", {16'b0, count_val}, 32'h1);
    tick(0); tick(0);
    trig = 1'b1; int_tick[0] = 1'b1; @(negedge clk); trig = 1'b0; int_tick = '0;
    check("R8 coincident trigger", {16'b0, count_val}, 32'h0);

    // R9: enable freezes the count
    tick(0);
    chan_en = 1'b0;
    for (int k = 0; k < 4; k++) tick(0);
    check("R9 frozen", {16'b0, count_val}, 32'h1);
    chan_en = 1'b1;
    tick(0);
    check("R9 resumes", {16'b0, count_val}, 32'h2);

    // R6 R7: wrap with a simultaneous status read
    trig = 1'b1; int_tick[0] = 1'b1; @(negedge clk); trig = 1'b0;
    wait_cyc(65535);
    int_tick = '0;
    check("R6 at all ones", {16'b0, count_val}, 32'hFFFF);
    check("R6 no flag yet", {31'b0, ovf_flag}, 32'h0);
    sts_rd = 1'b1; int_tick[0] = 1'b1; @(negedge clk); sts_rd = 1'b0; int_tick = '0;
    check("R6 wrap to zero", {16'b0, count_val}, 32'h0);
    check("R7 set wins over read", {31'b0, ovf_flag}, 32'h1);
    tick(0); tick(0);
    check("R6 flag sticky", {31'b0, ovf_flag}, 32'h1);
    sts_rd = 1'b1; @(negedge clk); sts_rd = 1'b0;
    check("R7 read clears", {31'b0, ovf_flag}, 32'h0);
    check("R7 count kept", {16'b0, count_val}, 32'h2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule